// File: doc/BRIEF.md
# Serial-Search Code Acquisition Controller

This block brings a direct-sequence spread-spectrum receiver into coarse code alignment before a tracking loop takes over. It holds a local maximal-length spreading code, produced by a linear feedback shift register and spread over several samples per chip. It multiplies each received sample by the current local chip and sums the products over one whole code period. At the end of that window it latches the magnitude of the sum and clears the accumulator on the same clock edge. It then compares the latched magnitude with a programmable threshold.

When the magnitude falls short of the threshold, the local code is held still for half a chip. This slides it back by one half-chip step against the received stream, and a fresh window begins. The phase index counts these steps. After one step for every half-chip position in the code, the index wraps to zero and the code is back at its starting alignment. When the magnitude reaches the threshold, the block raises its lock flag and lets the code run freely. A loss-of-lock report from the tracking stage while locked resets the code generator and the phase index, and the search starts again.

There are three states. ST_INTEG accumulates. ST_SLIP holds the code for two strobes. ST_LOCKED is the lock state. The transitions are as follows:
- ST_INTEG goes to ST_LOCKED on a dump whose magnitude is at or above the threshold (hit).
- ST_INTEG goes to ST_SLIP on a dump below the threshold (miss).
- ST_SLIP goes back to ST_INTEG on its second strobe (slip done).
- ST_LOCKED goes to ST_INTEG when the loss-of-lock input is high (restart).

Top module: `acq_serial_search`

## Requirements
- R1: After reset, `locked` is 0, `phase_idx` is 0 and `corr_mag` is 0.
- R2: The local code comes from a 3-bit register seeded with 001. On each chip step the register shifts left and takes in, as its new bit 0, the parity of (state AND 110). The chip is bit 2 of the register. Each chip lasts 4 accepted strobes. A chip of 1 adds the sample to the sum, and a chip of 0 subtracts it.
- R3: In ST_INTEG the block sums 28 strobed samples (4 per chip times a 7-chip code). On the 28th strobe, `corr_mag` takes the absolute value of the full sum and the accumulator is cleared on the same edge, so the next window starts from zero.
- R4: `corr_mag` changes only on the strobe that ends a window.
- R5: When the window magnitude is greater than or equal to `thresh`, `locked` is 1 from that same edge on. A magnitude exactly equal to the threshold locks.
- R6: A window magnitude below `thresh` increments `phase_idx`. The next 2 strobes are neither integrated nor allowed to advance the code, and the strobe after them starts a new window.
- R7: `phase_idx` counts 0 to 13 and wraps to 0 after 13. After 14 misses the local code is back at its original alignment.
- R8: `trk_lost` high while locked clears `locked` and `phase_idx` on the next edge, reloads the code generator with its seed at chip start, and drops any strobe in that cycle. The next strobe opens a new window.
- R9: `trk_lost` has no effect while the block is not locked.
- R10: A cycle without a strobe changes none of the outputs, unless it is a restart under R8.
- R11: While locked, `phase_idx` and `corr_mag` hold and the code keeps advancing on every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 8 | Signed received sample |
| thresh | input | 14 | Unsigned lock threshold on the magnitude |
| trk_lost | input | 1 | Loss-of-lock report from tracking |
| locked | output | 1 | Lock flag |
| phase_idx | output | 4 | Number of half-chip steps taken, modulo 14 |
| corr_mag | output | 14 | Latched magnitude of the last window |

## Verification
The hard situation is a lock at the one correct phase after several misses, with the wrap of the phase index seen along the way. A plain random stream almost never crosses a realistic threshold. The stimulus therefore builds a noisy replica of the code, started an even number of samples ahead, and predicts the phase index at which lock must occur. Separate runs use an unreachable threshold to force wraps while loss-of-lock pulses and idle cycles are mixed in. A window of known samples pins the threshold at exactly the magnitude, and at one above it.

// File: rtl/acq_pkg.sv
package acq_pkg;
    typedef enum logic [1:0] {
        ST_INTEG  = 2'd0,
        ST_SLIP   = 2'd1,
        ST_LOCKED = 2'd2
    } acq_state_t;
endpackage

// File: rtl/acq_code_gen.sv
// Local spreading code: m-sequence register stepped once per chip,
// with a sub-chip counter that stretches every chip over SPC strobes.
module acq_code_gen #(
    parameter int              LFSR_W = 3,
    parameter logic [LFSR_W-1:0] TAPS = 3'b110,
    parameter logic [LFSR_W-1:0] SEED = 3'b001,
    parameter int              SPC    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    output logic chip
);
    localparam int SUB_W = (SPC > 1) ? $clog2(SPC) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SPC - 1);

    logic [LFSR_W-1:0] lfsr_q;
    logic [SUB_W-1:0]  sub_q;
    logic              fb;

    assign fb   = ^(lfsr_q & TAPS);
    assign chip = lfsr_q[LFSR_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
            sub_q  <= '0;
        end else if (restart) begin
            lfsr_q <= SEED;
            sub_q  <= '0;
        end else if (step) begin
            if (sub_q == SUB_LAST) begin
                sub_q  <= '0;
                lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/acq_integ.sv
// Integrate-and-dump: latch the magnitude and clear on the same edge.
module acq_integ #(
    parameter int SAMPLE_W  = 8,
    parameter int INTEG_LEN = 28,
    parameter int ACC_W     = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       add,
    input  logic                       chip,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic                       dump,
    output logic [ACC_W-1:0]           mag_now,
    output logic [ACC_W-1:0]           corr_q
);
    localparam int CNT_W = $clog2(INTEG_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTEG_LEN - 1);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] term;
    logic signed [ACC_W-1:0] sum;
    logic [CNT_W-1:0]        cnt_q;

    always_comb begin
        ext     = {{(ACC_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
        term    = chip ? ext : -ext;
        sum     = acc_q + term;
        mag_now = sum[ACC_W-1] ? $unsigned(-sum) : $unsigned(sum);
    end

    assign dump = add && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            corr_q <= '0;
        end else if (add) begin
            if (dump) begin
                acc_q  <= '0;
                cnt_q  <= '0;
                corr_q <= mag_now;
            end else begin
                acc_q <= sum;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/acq_serial_search.sv
module acq_serial_search
    import acq_pkg::*;
#(
    parameter int              SAMPLE_W = 8,
    parameter int              LFSR_W   = 3,
    parameter logic [LFSR_W-1:0] TAPS   = 3'b110,
    parameter logic [LFSR_W-1:0] SEED   = 3'b001,
    parameter int              SPC      = 4,
    parameter int              ACC_W    = SAMPLE_W + $clog2(SPC * ((2**LFSR_W) - 1)) + 1,
    parameter int              PHASE_W  = $clog2(2 * ((2**LFSR_W) - 1))
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_vld,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic [ACC_W-1:0]           thresh,
    input  logic                       trk_lost,
    output logic                       locked,
    output logic [PHASE_W-1:0]         phase_idx,
    output logic [ACC_W-1:0]           corr_mag
);
    localparam int CODE_LEN  = (2**LFSR_W) - 1;
    localparam int INTEG_LEN = SPC * CODE_LEN;
    localparam int NUM_PHASE = 2 * CODE_LEN;
    localparam int SLIP_LEN  = SPC / 2;
    localparam int SLIP_W    = $clog2(SLIP_LEN + 1);
    localparam logic [SLIP_W-1:0]  SLIP_LAST  = SLIP_W'(SLIP_LEN - 1);
    localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(NUM_PHASE - 1);

    acq_state_t          state_q, state_d;
    logic [SLIP_W-1:0]   slip_q;
    logic [PHASE_W-1:0]  phase_q;
    logic                restart, code_step, integ_add, chip;
    logic                dump, hit;
    logic [ACC_W-1:0]    mag_now;

    assign restart   = (state_q == ST_LOCKED) && trk_lost;
    assign code_step = smp_vld && !restart && (state_q != ST_SLIP);
    assign integ_add = smp_vld && (state_q == ST_INTEG);
    assign hit       = (mag_now >= thresh);

    acq_code_gen #(
        .LFSR_W (LFSR_W),
        .TAPS   (TAPS),
        .SEED   (SEED),
        .SPC    (SPC)
    ) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .step    (code_step),
        .chip    (chip)
    );

    acq_integ #(
        .SAMPLE_W  (SAMPLE_W),
        .INTEG_LEN (INTEG_LEN),
        .ACC_W     (ACC_W)
    ) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .add     (integ_add),
        .chip    (chip),
        .sample  (smp_data),
        .dump    (dump),
        .mag_now (mag_now),
        .corr_q  (corr_mag)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INTEG: begin
                if (dump) state_d = hit ? ST_LOCKED : ST_SLIP;
            end
            ST_SLIP: begin
                if (smp_vld && (slip_q == SLIP_LAST)) state_d = ST_INTEG;
            end
            ST_LOCKED: begin
                if (trk_lost) state_d = ST_INTEG;
            end
            default: state_d = ST_INTEG;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INTEG;
        else        state_q <= state_d;
    end

    // Slip counter and phase index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slip_q  <= '0;
            phase_q <= '0;
        end else begin
            if ((state_q == ST_SLIP) && smp_vld)
                slip_q <= (slip_q == SLIP_LAST) ? '0 : slip_q + 1'b1;
            if (restart)
                phase_q <= '0;
            else if (dump && !hit)
                phase_q <= (phase_q == PHASE_LAST) ? '0 : phase_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        locked    = (state_q == ST_LOCKED);
        phase_idx = phase_q;
    end
endmodule

// File: rtl/acq_serial_search_chk.sv
module acq_serial_search_chk #(
    parameter int PHASE_W   = 4,
    parameter int ACC_W     = 14,
    parameter int NUM_PHASE = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               smp_vld,
    input logic               trk_lost,
    input logic [ACC_W-1:0]   thresh,
    input logic               locked,
    input logic [PHASE_W-1:0] phase_idx,
    input logic [ACC_W-1:0]   corr_mag
);
    localparam logic [PHASE_W-1:0] PLAST = PHASE_W'(NUM_PHASE - 1);

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_idx <= PLAST); // R7

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && smp_vld) |=> (phase_idx == $past(phase_idx)) ||
            (phase_idx == (($past(phase_idx) == PLAST) ? '0 : $past(phase_idx) + 1'b1))); // R6

    AST_LOCK_AT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (corr_mag >= $past(thresh))); // R5

    AST_LOCK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !smp_vld) |=> !locked); // R5

    AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(trk_lost)); // R8

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && trk_lost) |=> (!locked && phase_idx == '0)); // R8

    AST_CORR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(corr_mag)); // R4

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && !trk_lost) |=> ($stable(phase_idx) && $stable(locked))); // R10

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !trk_lost) |=> (locked && $stable(phase_idx) && $stable(corr_mag))); // R11
endmodule

bind acq_serial_search acq_serial_search_chk #(
    .PHASE_W   (PHASE_W),
    .ACC_W     (ACC_W),
    .NUM_PHASE (NUM_PHASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .trk_lost  (trk_lost),
    .thresh    (thresh),
    .locked    (locked),
    .phase_idx (phase_idx),
    .corr_mag  (corr_mag)
);

// File: tb/test_acq_serial_search.sv
module test_acq_serial_search;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int WIN        = 28;
    localparam int NPH        = 14;
    localparam int AMP        = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_vld = 1'b0;
    logic              trk_lost = 1'b0;
    logic signed [7:0] smp_data = '0;
    logic [13:0]       thresh = '0;
    logic              locked;
    logic [3:0]        phase_idx;
    logic [13:0]       corr_mag;

    acq_serial_search i_acq_serial_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .smp_data  (smp_data),
        .thresh    (thresh),
        .trk_lost  (trk_lost),
        .locked    (locked),
        .phase_idx (phase_idx),
        .corr_mag  (corr_mag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected-behaviour model, transaction level (0 integ, 1 slip, 2 locked)
    int       m_state, m_sub, m_cnt, m_acc, m_slip, m_phase, m_corr;
    logic [2:0] m_lfsr;
    // transmitted replica
    logic [2:0] t_lfsr;
    int         t_sub;

    function automatic logic [2:0] lfsr_next(input logic [2:0] s);
        return {s[1:0], s[2] ^ s[1]};   // taps 110 per R2
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int seed_corr(input int arr[WIN]);
        logic [2:0] s = 3'b001;
        int sub = 0;
        int sum = 0;
        for (int i = 0; i < WIN; i++) begin
            sum += s[2] ? arr[i] : -arr[i];
            if (sub == 3) begin sub = 0; s = lfsr_next(s); end
            else sub++;
        end
        return iabs(sum);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_lfsr = 3'b001; m_sub = 0; m_cnt = 0;
        m_acc = 0; m_slip = 0; m_phase = 0; m_corr = 0;
    endtask

    task automatic code_adv();
        if (m_sub == 3) begin m_sub = 0; m_lfsr = lfsr_next(m_lfsr); end
        else m_sub++;
    endtask

    task automatic model_step(input bit vld, input int x, input bit lost, input int th);
        if (m_state == 2 && lost) begin
            m_state = 0; m_lfsr = 3'b001; m_sub = 0; m_phase = 0;
            return;
        end
        if (!vld) return;
        case (m_state)
            0: begin
                m_acc += m_lfsr[2] ? x : -x;
                code_adv();
                if (m_cnt == WIN - 1) begin
                    m_corr = iabs(m_acc); m_acc = 0; m_cnt = 0;
                    if (m_corr >= th) m_state = 2;
                    else begin m_phase = (m_phase + 1) % NPH; m_state = 1; m_slip = 0; end
                end else m_cnt++;
            end
            1: begin
                if (m_slip == 1) begin m_state = 0; m_slip = 0; end
                else m_slip++;
            end
            default: code_adv();
        endcase
    endtask

    task automatic step(input bit vld, input int x, input bit lost, input string req);
        smp_vld  = vld;
        smp_data = 8'(x);
        trk_lost = lost;
        model_step(vld, x, lost, int'(thresh));
        @(negedge clk);
        smp_vld  = 1'b0;
        trk_lost = 1'b0;
        chk(req, "locked", int'(locked), int'(m_state == 2));
        chk(req, "phase_idx", int'(phase_idx), m_phase);
        chk(req, "corr_mag", int'(corr_mag), m_corr);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    task automatic tx_next(output int x);
        x = (t_lfsr[2] ? AMP : -AMP) + int'($urandom_range(16)) - 8;
        if (t_sub == 3) begin t_sub = 0; t_lfsr = lfsr_next(t_lfsr); end
        else t_sub++;
    endtask

    function automatic int rnd_smp();
        return int'($urandom_range(255)) - 128;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual expired expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int arr[WIN];
        int mag;
        int x;
        int k;
        bit wrapped;
        int prev_ph;
        void'($urandom(32'h5EED1234));
        model_reset();
        do_reset();

        // R1 reset state
        chk("R1", "locked", int'(locked), 0);
        chk("R1", "phase_idx", int'(phase_idx), 0);
        chk("R1", "corr_mag", int'(corr_mag), 0);

        // R3/R6 threshold one above magnitude: miss, then slip
        for (int i = 0; i < WIN; i++) arr[i] = rnd_smp();
        mag = seed_corr(arr);
        thresh = 14'(mag + 1);
        for (int i = 0; i < WIN; i++) step(1'b1, arr[i], 1'b0, "R3");
        chk("R3", "window magnitude", int'(corr_mag), mag);
        chk("R6", "no lock below", int'(locked), 0);
        chk("R6", "phase after miss", int'(phase_idx), 1);
        for (int i = 0; i < 4; i++) step(1'b1, rnd_smp(), 1'b0, "R6");

        // R5 threshold equal to magnitude locks
        do_reset();
        thresh = 14'(mag);
        for (int i = 0; i < WIN; i++) step(1'b1, arr[i], 1'b0, "R5");
        chk("R5", "lock at equal", int'(locked), 1);

        // R11 locked: outputs held
        for (int i = 0; i < 40; i++) step(($urandom_range(3) != 0), rnd_smp(), 1'b0, "R11");
        chk("R11", "corr held", int'(corr_mag), mag);

        // R8 restart on loss of lock, code back at seed
        step(1'b0, 0, 1'b1, "R8");
        chk("R8", "unlocked", int'(locked), 0);
        chk("R8", "phase cleared", int'(phase_idx), 0);
        for (int i = 0; i < WIN; i++) step(1'b1, arr[i], 1'b0, "R8");
        chk("R8", "relock from seed", int'(locked), 1);
        chk("R8", "relock magnitude", int'(corr_mag), mag);

        // R7/R9/R10 unreachable threshold, random lost pulses and idles
        do_reset();
        thresh = '1;
        wrapped = 1'b0;
        prev_ph = 0;
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom_range(9));
            if (r == 0) step(1'b0, 0, 1'b0, "R10");
            else if (r == 1) step($urandom_range(1) == 1, rnd_smp(), 1'b1, "R9");
            else step(1'b1, rnd_smp(), 1'b0, "R7");
            if (prev_ph == NPH - 1 && phase_idx == 0) wrapped = 1'b1;
            prev_ph = int'(phase_idx);
        end
        chk("R7", "phase wrap seen", int'(wrapped), 1);
        chk("R9", "never locked", int'(locked), 0);

        // R2/R6 lock onto an offset replica at the predicted phase
        for (int n = 0; n < 4; n++) begin
            do_reset();
            thresh = 14'd880;
            k = 2 * int'($urandom_range(13));
            if (n == 0) k = 26;
            t_lfsr = 3'b001;
            t_sub = 0;
            for (int i = 0; i < k; i++) tx_next(x);
            for (int i = 0; i < 500 && !locked; i++) begin
                tx_next(x);
                step(1'b1, x, 1'b0, "R2");
            end
            chk("R2", "replica locked", int'(locked), 1);
            chk("R6", "lock phase", int'(phase_idx), ((WIN - k) / 2) % NPH);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule